// File: doc/BRIEF.md
# Multi-channel result FIFO bank

This block sits between a converter and the memory-transfer side of a chip. It holds six independent queues. Each queue stores up to four 16-bit results. The converter side writes a result into a queue through that queue's own push strobe. The bus side takes the oldest result out by reading that queue's pop register. Every result passes through a queue on its way to memory.

For each queue the block keeps a fill count and a non-empty flag. It raises a request when a queue holds data and its enable bit is set. A per-queue select bit decides whether that request goes to the CPU interrupt output or to the DMA request output. A push to a full queue is dropped and sets a sticky overflow bit, which software clears by writing 1 to it.

The register interface is a plain single-cycle strobe bus. Read data comes back one cycle after the read strobe, qualified by a valid pulse.

Top module: `rfifo_bank`

## Requirements
- R1: The bank has six independent first-in first-out queues, each four entries of 16 bits. Entries are read out of a queue in the order they were pushed, and traffic on one queue never changes another.
- R2: Reading address 16+n returns the fill count (0 to 4) of queue n in bits [2:0]. Reading address 10 returns the non-empty flag of queue n in bit n.
- R3: A push to a queue that holds 4 entries, with no pop of that queue in the same cycle, is dropped, and it sets overflow bit 8+n of the status word at address 10. Writing 1 to that bit clears it. If a clear and a new drop land in the same cycle, the bit stays set.
- R4: A read strobe at address n (0 to 5) returns the oldest entry of queue n on bus_rdata one cycle later, with bus_rvalid high. It removes exactly one entry for every access size (bus_size 0 = byte, 1 = halfword, 2 = word).
- R5: A read of the pop register of an empty queue returns zero and leaves the count and contents unchanged.
- R6: A push and a pop to the same non-empty queue in one cycle both take effect, and the count is unchanged, even when the queue is full. On an empty queue the pop returns zero and the pushed entry is kept.
- R7: The enable register at address 8 and the select register at address 9 each hold one bit per queue in bits [5:0]. irq_req[n] is high exactly when queue n is non-empty, enabled and has select 0. dma_req[n] is high exactly when queue n is non-empty, enabled and has select 1. Both are registered and track the queue state after each clock edge.
- R8: After reset every queue is empty, and enable, select and overflow are all 0. No request is raised and bus_rvalid is low.
- R9: Reads of addresses other than the pop registers, and writes to pop-register addresses, leave every queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 6 | Push strobe, one per queue |
| push_data | input | 96 | Push data, queue n in bits [16n+15:16n] |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 16 | Write data; unused bits must be zero |
| bus_rdata | output | 16 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | output | 6 | Interrupt request per queue |
| dma_req | output | 6 | DMA request per queue |

## Verification
The hardest states to reach are the edges of a queue that coincide with a second event in the same cycle. These are a push and a pop meeting on a full queue, a push and a pop meeting on an empty queue, and an overflow clear arriving in the very cycle a new push is dropped. The bench first fills a queue to exactly four entries with directed pushes. It then issues the push strobe and the bus access together in a single cycle, so each collision happens on purpose rather than by chance. A long random phase follows, with mixed pushes, pops and register reads. A queue-based model checks the requests and read data on every clock.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  // Register addresses (pop registers occupy 0 .. NUM_CH-1)
  localparam int ADDR_EN       = 8;
  localparam int ADDR_SEL      = 9;
  localparam int ADDR_STAT     = 10;
  localparam int ADDR_CNT_BASE = 16;
  // Bit position of the overflow field inside the status word
  localparam int OVF_LSB       = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/rfifo_chan.sv
module rfifo_chan #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              nonempty_nxt_o,
  output logic              drop_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              pop_eff, push_eff;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_eff  = pop_i && (cnt_q != '0);
  assign push_eff = push_i && ((cnt_q < CNT_W'(DEPTH)) || pop_eff);
  assign drop_o   = push_i && !push_eff;
  assign cnt_nxt  = cnt_q + CNT_W'(push_eff) - CNT_W'(pop_eff);

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push_eff) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_eff)  rd_ptr <= ptr_inc(rd_ptr);
      if (push_eff) wr_ptr <= ptr_inc(wr_ptr);
      cnt_q <= cnt_nxt;
    end
  end

  assign head_o         = (cnt_q != '0) ? mem[rd_ptr] : '0;
  assign cnt_o          = cnt_q;
  assign nonempty_nxt_o = (cnt_nxt != '0);

  // R2: the count never exceeds the depth
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  // R4: a lone pop of a non-empty queue removes exactly one entry
  a_r4_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R5: a pop of an empty queue changes nothing
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && cnt_q == '0) |=> (cnt_q == '0) && $stable(rd_ptr));
  // R6: push and pop together on a non-empty queue hold the count
  a_r6_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (pop_i && push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q));
  // R3: a push into a full queue without a pop is dropped
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && cnt_q == CNT_W'(DEPTH)) |=> (cnt_q == CNT_W'(DEPTH)) && $stable(wr_ptr));
endmodule

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl
  import rfifo_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] drop_i,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] sel_q,
  output logic [NUM_CH-1:0] ovf_q,
  output logic [NUM_CH-1:0] en_nxt,
  output logic [NUM_CH-1:0] sel_nxt
);
  logic [NUM_CH-1:0] clr_vec, ovf_nxt;
  logic              wr_en, wr_sel, wr_stat;

  assign wr_en   = wr_i && (addr_i == ADDR_W'(ADDR_EN));
  assign wr_sel  = wr_i && (addr_i == ADDR_W'(ADDR_SEL));
  assign wr_stat = wr_i && (addr_i == ADDR_W'(ADDR_STAT));

  assign en_nxt  = wr_en  ? wdata_i[NUM_CH-1:0] : en_q;
  assign sel_nxt = wr_sel ? wdata_i[NUM_CH-1:0] : sel_q;
  assign clr_vec = wr_stat ? wdata_i[OVF_LSB +: NUM_CH] : '0;
  // a new drop wins over a clear in the same cycle
  assign ovf_nxt = (ovf_q & ~clr_vec) | drop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= '0;
      ovf_q <= '0;
    end else begin
      en_q  <= en_nxt;
      sel_q <= sel_nxt;
      ovf_q <= ovf_nxt;
    end
  end

  // R3: overflow bits stay set until cleared
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ovf_q) & ~$past(clr_vec)) & ~ovf_q) == '0);
  // R3: every dropped push is recorded
  a_r3_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (drop_i != '0) |=> (ovf_q & $past(drop_i)) == $past(drop_i));
endmodule

// File: rtl/rfifo_bank.sv
module rfifo_bank
  import rfifo_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        push_valid,
  input  logic [NUM_CH*DATA_W-1:0] push_data,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  output logic [NUM_CH-1:0]        irq_req,
  output logic [NUM_CH-1:0]        dma_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [DATA_W-1:0] WMASK =
    DATA_W'({NUM_CH{1'b1}}) | (DATA_W'({NUM_CH{1'b1}}) << OVF_LSB);

  logic [DATA_W-1:0] head [NUM_CH];
  logic [CNT_W-1:0]  cnt  [NUM_CH];
  logic [NUM_CH-1:0] pop_vec, nonempty_nxt, nonempty_q, drop_vec;
  logic [NUM_CH-1:0] en_q, sel_q, ovf_q, en_nxt, sel_nxt;
  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign pop_vec[i]    = bus_rd && (bus_addr == ADDR_W'(i));
    assign nonempty_q[i] = (cnt[i] != '0);

    rfifo_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chan (
      .clk            (clk),
      .rst            (rst),
      .push_i         (push_valid[i]),
      .push_data_i    (push_data[i*DATA_W +: DATA_W]),
      .pop_i          (pop_vec[i]),
      .head_o         (head[i]),
      .cnt_o          (cnt[i]),
      .nonempty_nxt_o (nonempty_nxt[i]),
      .drop_o         (drop_vec[i])
    );
  end

  rfifo_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .drop_i  (drop_vec),
    .en_q    (en_q),
    .sel_q   (sel_q),
    .ovf_q   (ovf_q),
    .en_nxt  (en_nxt),
    .sel_nxt (sel_nxt)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i))                 rd_mux = head[i];
      if (bus_addr == ADDR_W'(ADDR_CNT_BASE + i)) rd_mux = DATA_W'(cnt[i]);
    end
    if (bus_addr == ADDR_W'(ADDR_EN))  rd_mux = DATA_W'(en_q);
    if (bus_addr == ADDR_W'(ADDR_SEL)) rd_mux = DATA_W'(sel_q);
    if (bus_addr == ADDR_W'(ADDR_STAT)) begin
      rd_mux = DATA_W'(nonempty_q);
      rd_mux[OVF_LSB +: NUM_CH] = ovf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      irq_req    <= '0;
      dma_req    <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      irq_req <= en_nxt & ~sel_nxt & nonempty_nxt;
      dma_req <= en_nxt &  sel_nxt & nonempty_nxt;
    end
  end

  // R7: a queue never drives both request kinds
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    (irq_req & dma_req) == '0);
  // R7: a request implies the queue holds data
  a_r7_needs_data: assert property (@(posedge clk) disable iff (rst)
    ((irq_req | dma_req) & ~nonempty_q) == '0);
  // R4: only defined access sizes are used
  a_r4_size_legal: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> bus_size != 2'b11);
  // R7: reserved write-data bits are written as zero
  a_r7_wdata_rsvd: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_wdata & ~WMASK) == '0);
  // R9: reads and writes are never issued together
  a_r9_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
endmodule

// File: tb/rfifo_bank_bench.sv
module rfifo_bank_bench;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCH-1:0]    push_valid;
  logic [NCH*DW-1:0] push_data;
  logic              bus_rd, bus_wr;
  logic [4:0]        bus_addr;
  logic [1:0]        bus_size;
  logic [DW-1:0]     bus_wdata;
  logic [DW-1:0]     bus_rdata;
  logic              bus_rvalid;
  logic [NCH-1:0]    irq_req, dma_req;

  rfifo_bank u_rfifo_bank (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  // reference model
  logic [DW-1:0]  mq [NCH][$];
  logic [NCH-1:0] m_en, m_sel, m_ovf;
  logic [DW-1:0]  m_rdata;
  logic           m_rvalid;
  string          tag;
  int             n_chk = 0, n_fail = 0;
  bit             done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] m_nonempty();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = (mq[c].size() != 0);
    return v;
  endfunction

  task automatic model_edge();
    logic [DW-1:0] rd;
    rd = '0;
    if (rst) begin
      for (int c = 0; c < NCH; c++) mq[c].delete();
      m_en = '0; m_sel = '0; m_ovf = '0; m_rvalid = 1'b0;
      return;
    end
    if (bus_rd) begin
      if (bus_addr < NCH) begin
        if (mq[bus_addr].size() != 0) rd = mq[bus_addr].pop_front();
      end else if (bus_addr == 8) rd = DW'(m_en);
      else if (bus_addr == 9) rd = DW'(m_sel);
      else if (bus_addr == 10) rd = {2'b0, m_ovf, 2'b0, m_nonempty()};
      else if (bus_addr >= 16 && bus_addr < 16 + NCH) rd = DW'(mq[bus_addr - 16].size());
      m_rdata = rd;
    end
    m_rvalid = bus_rd;
    if (bus_wr) begin
      if (bus_addr == 8) m_en = bus_wdata[NCH-1:0];
      if (bus_addr == 9) m_sel = bus_wdata[NCH-1:0];
      if (bus_addr == 10) m_ovf = m_ovf & ~bus_wdata[8 +: NCH];
    end
    for (int c = 0; c < NCH; c++)
      if (push_valid[c]) begin
        if (mq[c].size() < 4) mq[c].push_back(push_data[c*DW +: DW]);
        else m_ovf[c] = 1'b1;
      end
  endtask

  task automatic compare();
    logic [NCH-1:0] ne;
    ne = m_nonempty();
    check("R7 irq_req", irq_req, m_en & ~m_sel & ne);
    check("R7 dma_req", dma_req, m_en & m_sel & ne);
    check("R4 bus_rvalid", bus_rvalid, m_rvalid);
    if (m_rvalid) check({tag, " bus_rdata"}, bus_rdata, m_rdata);
  endtask

  task automatic clear_in();
    push_valid = '0; push_data = '0; bus_rd = 0; bus_wr = 0;
    bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    clear_in();
  endtask

  task automatic push1(int ch, logic [DW-1:0] d);
    push_valid[ch] = 1'b1; push_data[ch*DW +: DW] = d; step();
  endtask

  task automatic rd1(int a, int sz = 2);
    bus_rd = 1; bus_addr = 5'(a); bus_size = 2'(sz); step(); step();
  endtask

  task automatic wr1(int a, logic [DW-1:0] d);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = d; step();
  endtask

  initial begin
    #(64'd8 * 200000);
    if (!done) begin
      done = 1; n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) step();
    rst = 0;
    // R8: reset state
    tag = "R8";
    check("R8 irq after reset", irq_req, 0);
    check("R8 dma after reset", dma_req, 0);
    check("R8 rvalid after reset", bus_rvalid, 0);
    rd1(10); rd1(8); rd1(9); rd1(16);

    // R1: ordering, independence
    tag = "R1";
    for (int k = 0; k < 4; k++) begin
      push1(2, 16'h2A00 + 16'(k));
      push1(5, 16'h5B00 + 16'(k));
    end
    tag = "R2"; rd1(18); rd1(21); rd1(16); rd1(10);
    tag = "R1";
    for (int k = 0; k < 4; k++) rd1(2);
    tag = "R2"; rd1(18); rd1(21);

    // R3: overflow, W1C, set wins
    tag = "R3";
    for (int k = 0; k < 5; k++) push1(0, 16'hC000 + 16'(k));
    rd1(10); rd1(16);
    wr1(10, 16'h0100); rd1(10);
    push_valid[0] = 1; push_data[15:0] = 16'hDEAD;
    bus_wr = 1; bus_addr = 5'd10; bus_wdata = 16'h0100; step();
    rd1(10);
    wr1(10, 16'h3F00); rd1(10);

    // R4: pops with every size
    tag = "R4";
    rd1(0, 0); rd1(0, 1); rd1(0, 2); rd1(16);

    // R5: pop of empty queue
    tag = "R5";
    rd1(3); rd1(19); rd1(3, 0); rd1(19);

    // R6: push and pop together, full and empty
    tag = "R6";
    for (int k = 0; k < 4; k++) push1(1, 16'h1100 + 16'(k));
    push_valid[1] = 1; push_data[DW +: DW] = 16'h11FF;
    bus_rd = 1; bus_addr = 5'd1; step(); step();
    rd1(17); rd1(10);
    for (int k = 0; k < 4; k++) rd1(1);
    push_valid[4] = 1; push_data[4*DW +: DW] = 16'h4444;
    bus_rd = 1; bus_addr = 5'd4; step(); step();
    rd1(20); rd1(4);

    // R7: request routing
    tag = "R7";
    push1(0, 16'h0007); push1(3, 16'h0307);
    wr1(8, 16'h003F); step();
    wr1(9, 16'h0008); step();
    rd1(8); rd1(9);
    wr1(8, 16'h0001); step();
    rd1(0); rd1(3);

    // R9: no side effects
    tag = "R9";
    push1(2, 16'h2222);
    wr1(2, 16'h0000); rd1(18); rd1(8); rd1(9); rd1(20); rd1(18);

    // random mix
    tag = "R1";
    wr1(8, 16'h003F);
    for (int n = 0; n < 600; n++) begin
      int r;
      push_valid = NCH'($urandom);
      for (int c = 0; c < NCH; c++) push_data[c*DW +: DW] = DW'($urandom);
      r = $urandom_range(0, 3);
      if (r != 0) begin
        int s;
        s = $urandom_range(0, 13);
        bus_rd = 1;
        bus_size = 2'($urandom_range(0, 2));
        bus_addr = (s < 6) ? 5'(s) : (s < 8) ? 5'(s + 2) : 5'(s + 8);
      end else if ($urandom_range(0, 7) == 0) begin
        bus_wr = 1; bus_addr = 5'd9; bus_wdata = DW'(NCH'($urandom));
      end
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule